// File: doc/BRIEF.md
# Manchester II Word Encoder

This block turns a 16-bit word, delivered one bit at a time by an external source, into a self-clocking bipolar frame for a serial bus. Each frame lasts twenty bit times. It opens with a three-bit-time sync mark, which is either a command type or a data type. Sixteen Manchester-coded data bits follow, and a final bit gives the word odd parity. The line is driven as two active-low levels, one for the positive sense and one for the negative sense of the bus. Both levels sit high while the encoder is idle or inhibited.

Everything runs on one clock, `clk`. An optional divide-by-`DIV` prescaler, default six, makes a half-bit tick from that clock. With the default, `clk` is the 12x bit-rate clock. With `DIV = 1`, `clk` is already the 2x send clock. The block puts out `shift_clk`, a free-running square wave at the bit rate. Each bit period starts on a rising edge of `shift_clk`, and its falling edge falls mid-bit. The host raises `enable`, and the encoder fetches the word through the `send_data` request window. This window is the block's only data stream interface. `send_data` plays the role of ready, and `sdi` carries the data. The stream has no back-pressure: the source cannot stall or refuse. For each bit period in which `send_data` is high, the source must place the next bit on `sdi`, most significant bit first, by the rising edge of `shift_clk` that ends that period.

Top module: `mce_encoder`

## Requirements
- R1: While `mrst` is high and after it falls with `enable` low, `bip_one_n` and `bip_zero_n` are both high and `send_data` is low.
- R2: A frame starts on the first rising edge of `shift_clk` after a falling edge at which `enable` is high. The first line half-bit appears while `shift_clk` is high. The frame is 40 half-bits long.
- R3: `sync_sel` is sampled at the frame-start edge. With 1, the first three half-bits are positive and the next three negative. With 0, the first three are negative and the next three positive.
- R4: Data bits go out MSB first, in bit times 4 to 19 of the frame. A 1 is positive in the first half and negative in the second; a 0 is the reverse. Positive drives `bip_one_n` low; negative drives `bip_zero_n` low.
- R5: Bit time 20 carries a parity bit, Manchester-coded like data, that makes the 16 data bits plus parity hold an odd number of ones.
- R6: `send_data` is high for exactly 16 bit periods of each frame. It changes only together with a rising edge of `shift_clk`. `sdi` is sampled at the rising edge that ends each period in the window.
- R7: If `enable` is still high at the falling edge of `shift_clk` in a frame's last bit time, the next frame follows with no idle half-bit between them.
- R8: If `enable` is low at that falling edge, the line returns to idle after the frame and stays idle.
- R9: `oinh_n` low forces both line outputs high from the next clock. Sequencing, `shift_clk` and `send_data` are unaffected.
- R10: A cycle of `mrst` high aborts a frame in progress. After that cycle the line is idle and `send_data` is low, and the next enabled word is encoded correctly.
- R11: `shift_clk` stays at each level for `DIV` clock cycles.
- R12: `bip_one_n` and `bip_zero_n` are never low at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (12x bit rate with the default prescaler) |
| mrst | input | 1 | Synchronous master reset and abort, active high |
| enable | input | 1 | Request to encode a word; sampled on falling edges of `shift_clk` |
| sync_sel | input | 1 | 1 selects command sync, 0 selects data sync |
| sdi | input | 1 | Serial data from the external source |
| oinh_n | input | 1 | Active-low line inhibit |
| shift_clk | output | 1 | Bit-rate shift clock |
| send_data | output | 1 | Serial data request window |
| bip_one_n | output | 1 | Active-low positive line drive |
| bip_zero_n | output | 1 | Active-low negative line drive |

## Verification
The assertions check on every cycle that the two line drives are never low together and that inhibit idles the line one cycle later. They also check that the line is idle right after a master reset, that `shift_clk` holds each level for `DIV` cycles, and that every `send_data` window changes only with a rising shift-clock edge and lasts sixteen bit periods. Only the bench scenarios can show frame content. A scoreboard decodes the line half-bit by half-bit to confirm each sync type, the MSB-first data, odd parity, gap-free back-to-back frames, a clean stop when `enable` drops, and correct recovery after an abort.

// File: rtl/mce_pkg.sv
package mce_pkg;
  // bit times occupied by the sync mark
  localparam int SYNC_SLOTS = 3;

  typedef enum logic [1:0] {
    SEG_IDLE,
    SEG_SYNC,
    SEG_DATA,
    SEG_PAR
  } seg_e;
endpackage

// File: rtl/mce_prescaler.sv
module mce_prescaler #(
  parameter int DIV = 6
) (
  input  logic clk,
  input  logic mrst,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_bypass
      assign tick = 1'b1;
    end else begin : g_count
      localparam int CW = $clog2(DIV);
      localparam logic [CW-1:0] TOP = CW'(DIV - 1);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk) begin
        if (mrst) cnt_q <= '0;
        else if (cnt_q == TOP) cnt_q <= '0;
        else cnt_q <= cnt_q + 1'b1;
      end
      assign tick = (cnt_q == TOP);
    end
  endgenerate
endmodule

// File: rtl/mce_sequencer.sv
module mce_sequencer
  import mce_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic clk,
  input  logic mrst,
  input  logic tick,
  input  logic enable,
  input  logic sync_sel,
  input  logic sdi,
  output logic shift_clk,
  output logic send_data,
  output logic active,
  output logic pos_level
);
  localparam int LAST_SLOT = SYNC_SLOTS + DATA_W;
  localparam int SLOT_W    = $clog2(LAST_SLOT + 1);
  localparam logic [SLOT_W-1:0] S_LAST  = SLOT_W'(LAST_SLOT);
  localparam logic [SLOT_W-1:0] S_SYNCE = SLOT_W'(SYNC_SLOTS);
  localparam logic [SLOT_W-1:0] S_REQ0  = SLOT_W'(SYNC_SLOTS - 1);
  localparam logic [SLOT_W-1:0] S_REQ1  = SLOT_W'(LAST_SLOT - 2);
  localparam logic [SLOT_W:0]   H_SYNC  = (SLOT_W+1)'(SYNC_SLOTS);

  logic              ph_q;     // 0: first half of bit, 1: second half
  logic              busy_q;
  logic              armed_q;
  logic              cmd_q;
  logic              bit_q;
  logic              par_q;
  logic [SLOT_W-1:0] slot_q;
  logic              in_req;
  logic [SLOT_W:0]   half_idx;
  seg_e              seg;

  assign in_req   = busy_q && (slot_q >= S_REQ0) && (slot_q <= S_REQ1);
  assign half_idx = {slot_q, ph_q};

  always_ff @(posedge clk) begin
    if (mrst) begin
      ph_q    <= 1'b0;
      busy_q  <= 1'b0;
      armed_q <= 1'b0;
      cmd_q   <= 1'b0;
      bit_q   <= 1'b0;
      par_q   <= 1'b0;
      slot_q  <= '0;
    end else if (tick) begin
      ph_q <= ~ph_q;
      if (!ph_q) begin
        // falling edge of shift_clk: look at enable
        if (enable && !armed_q && (!busy_q || slot_q == S_LAST))
          armed_q <= 1'b1;
      end else begin
        // rising edge of shift_clk: bit boundary
        if (armed_q) begin
          armed_q <= 1'b0;
          busy_q  <= 1'b1;
          slot_q  <= '0;
          cmd_q   <= sync_sel;
          par_q   <= 1'b1;
        end else if (busy_q) begin
          if (slot_q == S_LAST) busy_q <= 1'b0;
          else slot_q <= slot_q + 1'b1;
          if (in_req) begin
            bit_q <= sdi;
            par_q <= par_q ^ sdi;
          end
        end
      end
    end
  end

  always_comb begin
    if (!busy_q)              seg = SEG_IDLE;
    else if (slot_q < S_SYNCE) seg = SEG_SYNC;
    else if (slot_q < S_LAST)  seg = SEG_DATA;
    else                       seg = SEG_PAR;
  end

  always_comb begin
    unique case (seg)
      SEG_SYNC: pos_level = ((half_idx < H_SYNC) == cmd_q);
      SEG_DATA: pos_level = bit_q ^ ph_q;
      SEG_PAR:  pos_level = par_q ^ ph_q;
      default:  pos_level = 1'b0;
    endcase
  end

  assign active    = (seg != SEG_IDLE);
  assign shift_clk = ~ph_q;
  assign send_data = in_req;
endmodule

// File: rtl/mce_line.sv
module mce_line (
  input  logic clk,
  input  logic mrst,
  input  logic active,
  input  logic pos_level,
  input  logic oinh_n,
  output logic one_n,
  output logic zero_n
);
  logic drive;
  assign drive = active && oinh_n;

  always_ff @(posedge clk) begin
    if (mrst) begin
      one_n  <= 1'b1;
      zero_n <= 1'b1;
    end else begin
      one_n  <= ~(drive &&  pos_level);
      zero_n <= ~(drive && !pos_level);
    end
  end
endmodule

// File: rtl/mce_encoder.sv
module mce_encoder #(
  parameter int DATA_W = 16,
  parameter int DIV    = 6
) (
  input  logic clk,
  input  logic mrst,
  input  logic enable,
  input  logic sync_sel,
  input  logic sdi,
  input  logic oinh_n,
  output logic shift_clk,
  output logic send_data,
  output logic bip_one_n,
  output logic bip_zero_n
);
  logic tick;
  logic active;
  logic pos_level;

  mce_prescaler #(.DIV(DIV)) presc_i (
    .clk  (clk),
    .mrst (mrst),
    .tick (tick)
  );

  mce_sequencer #(.DATA_W(DATA_W)) seq_i (
    .clk       (clk),
    .mrst      (mrst),
    .tick      (tick),
    .enable    (enable),
    .sync_sel  (sync_sel),
    .sdi       (sdi),
    .shift_clk (shift_clk),
    .send_data (send_data),
    .active    (active),
    .pos_level (pos_level)
  );

  mce_line line_i (
    .clk       (clk),
    .mrst      (mrst),
    .active    (active),
    .pos_level (pos_level),
    .oinh_n    (oinh_n),
    .one_n     (bip_one_n),
    .zero_n    (bip_zero_n)
  );
endmodule

// File: rtl/mce_encoder_chk.sv
module mce_encoder_chk #(
  parameter int DATA_W = 16,
  parameter int DIV    = 6
) (
  input logic clk,
  input logic mrst,
  input logic oinh_n,
  input logic shift_clk,
  input logic send_data,
  input logic bip_one_n,
  input logic bip_zero_n
);
  localparam int WIN_CYC = 2 * DATA_W * DIV;

  int   win_cnt;
  int   run_cnt;
  logic sc_q;
  logic seen_q;

  always_ff @(posedge clk) begin
    if (mrst || !send_data) win_cnt <= 0;
    else win_cnt <= win_cnt + 1;
  end

  always_ff @(posedge clk) begin
    if (mrst) begin
      sc_q    <= 1'b1;
      seen_q  <= 1'b0;
      run_cnt <= 0;
    end else begin
      sc_q <= shift_clk;
      if (shift_clk != sc_q) begin
        run_cnt <= 1;
        seen_q  <= 1'b1;
      end else begin
        run_cnt <= run_cnt + 1;
      end
    end
  end

  // R12
  p_never_both_low_r12: assert property (@(posedge clk) disable iff (mrst)
    !(!bip_one_n && !bip_zero_n));

  // R9
  p_inhibit_idle_r9: assert property (@(posedge clk) disable iff (mrst)
    !oinh_n |=> (bip_one_n && bip_zero_n));

  // R10
  p_reset_idle_r10: assert property (@(posedge clk) disable iff (mrst)
    $fell(mrst) |-> (bip_one_n && bip_zero_n && !send_data));

  // R6
  p_strobe_edge_r6: assert property (@(posedge clk) disable iff (mrst)
    (!$stable(send_data) && !$past(mrst)) |-> $rose(shift_clk));

  // R6
  p_strobe_len_r6: assert property (@(posedge clk) disable iff (mrst)
    ($fell(send_data) && !$past(mrst)) |-> (win_cnt == WIN_CYC));

  // R11
  p_shift_period_r11: assert property (@(posedge clk) disable iff (mrst)
    ((shift_clk != sc_q) && seen_q) |-> (run_cnt == DIV));
endmodule

bind mce_encoder mce_encoder_chk #(.DATA_W(DATA_W), .DIV(DIV)) chk_i (
  .clk        (clk),
  .mrst       (mrst),
  .oinh_n     (oinh_n),
  .shift_clk  (shift_clk),
  .send_data  (send_data),
  .bip_one_n  (bip_one_n),
  .bip_zero_n (bip_zero_n)
);

// File: tb/mce_encoder_tb_top.sv
module mce_encoder_tb_top;
  localparam int DW        = 16;
  localparam int DIV       = 6;
  localparam int HALVES    = 2 * (3 + DW + 1);
  localparam int FRAME_CYC = HALVES * DIV;

  logic clk = 1'b0;
  logic mrst = 1'b1;
  logic enable = 1'b0;
  logic sync_sel = 1'b0;
  logic sdi = 1'b0;
  logic oinh_n = 1'b1;
  logic shift_clk, send_data, bip_one_n, bip_zero_n;

  always #4 clk = ~clk;

  mce_encoder #(.DATA_W(DW), .DIV(DIV)) dut_i (
    .clk(clk), .mrst(mrst), .enable(enable), .sync_sel(sync_sel),
    .sdi(sdi), .oinh_n(oinh_n), .shift_clk(shift_clk),
    .send_data(send_data), .bip_one_n(bip_one_n), .bip_zero_n(bip_zero_n)
  );

  typedef struct {
    bit          cmd;
    logic [15:0] data;
    bit          contig;
  } exp_t;

  exp_t        exp_q[$];
  logic [15:0] feed_q[$];
  int  n_cmp = 0;
  int  n_bad = 0;
  int  act_cycles = 0;
  bit  mon_en = 1'b1;
  bit  abort_win = 1'b0;
  bit  done = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // activity counter on the line
  initial forever begin
    @(negedge clk);
    if (!(bip_one_n && bip_zero_n)) act_cycles++;
  end

  // serial data source: changes sdi on falling shift_clk inside the window
  initial begin
    bit prev_sc = 1'b1;
    int idx = 0;
    logic [15:0] cur = '0;
    forever begin
      @(negedge clk);
      if (mrst) idx = 0;
      else if (prev_sc && !shift_clk && send_data) begin
        if (idx == 0) cur = (feed_q.size() > 0) ? feed_q.pop_front() : 16'h0;
        sdi <= cur[DW-1-idx];
        idx = (idx == DW-1) ? 0 : idx + 1;
      end
      prev_sc = shift_clk;
    end
  end

  // request window checker (R6)
  initial begin
    bit p = 1'b0;
    bit psc = 1'b1;
    int len = 0;
    forever begin
      @(negedge clk);
      if (send_data && !p) begin
        check(!psc && shift_clk, "R6", "window opens on shift_clk rise",
              {psc, shift_clk}, 2'b01);
        len = 1;
      end else if (send_data) begin
        len++;
      end else if (p && !abort_win) begin
        check(len == 2*DW*DIV, "R6", "window length cycles", len, 2*DW*DIV);
      end
      p = send_data;
      psc = shift_clk;
    end
  end

  // decode one frame; entered at the sample point of half 0
  task automatic decode_frame(input bit contig, output bit more);
    logic pos [HALVES];
    int   bad = 0;
    bit   cmd;
    bit   sync_ok;
    logic [15:0] d;
    logic par;
    exp_t e;
    for (int h = 0; h < HALVES; h++) begin
      if (bip_one_n == bip_zero_n) bad++;
      pos[h] = !bip_one_n;
      repeat (DIV) @(negedge clk);
    end
    more = !(bip_one_n && bip_zero_n);
    cmd = pos[0];
    sync_ok = (pos[0] == pos[1]) && (pos[1] == pos[2]) &&
              (pos[3] != pos[0]) && (pos[4] == pos[3]) && (pos[5] == pos[3]);
    for (int k = 0; k < DW; k++) begin
      d[DW-1-k] = pos[6+2*k];
      if (pos[7+2*k] == pos[6+2*k]) bad++;
    end
    par = pos[HALVES-2];
    if (pos[HALVES-1] == pos[HALVES-2]) bad++;
    if (exp_q.size() == 0) begin
      check(1'b0, "R8", "unexpected frame", d, 0);
    end else begin
      e = exp_q.pop_front();
      check(sync_ok && cmd == e.cmd, "R3", "sync type", {sync_ok, cmd}, {1'b1, e.cmd});
      check(d == e.data, "R4", "data word", d, e.data);
      check(par == ~^e.data, "R5", "parity bit", par, ~^e.data);
      check(bad == 0, "R12", "manchester half-bit errors", bad, 0);
      check(contig == e.contig, "R7", "frame adjacency", contig, e.contig);
    end
  endtask

  // scoreboard monitor
  initial begin
    bit idle_q = 1'b1;
    bit more;
    bit contig;
    forever begin
      @(negedge clk);
      if (mon_en && idle_q && !(bip_one_n && bip_zero_n)) begin
        check(shift_clk == 1'b1, "R2", "frame starts in shift_clk high", shift_clk, 1);
        repeat (DIV/2) @(negedge clk);
        contig = 1'b0;
        do begin
          decode_frame(contig, more);
          contig = 1'b1;
        end while (more);
      end
      idle_q = bip_one_n && bip_zero_n;
    end
  end

  task automatic wait_window_open();
    bit p = send_data;
    forever begin
      @(negedge clk);
      if (send_data && !p) break;
      p = send_data;
    end
  endtask

  task automatic send_word(input bit cmd, input logic [15:0] d, input bit last,
                           input bit contig, input bit expect_it);
    exp_t e;
    if (expect_it) begin
      e.cmd = cmd; e.data = d; e.contig = contig;
      exp_q.push_back(e);
    end
    feed_q.push_back(d);
    sync_sel = cmd;
    enable = 1'b1;
    wait_window_open();
    if (last) enable = 1'b0;
  endtask

  task automatic wait_quiet();
    int guard = 0;
    while (exp_q.size() != 0 && guard < 4*FRAME_CYC) begin
      @(negedge clk);
      guard++;
    end
    check(exp_q.size() == 0, "R2", "expected frames emitted", exp_q.size(), 0);
    repeat (FRAME_CYC) @(negedge clk);
  endtask

  initial begin
    #(200000 * 8);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int a0;
    int t0;
    repeat (5) @(negedge clk);
    // R1: reset state
    check(bip_one_n && bip_zero_n && !send_data, "R1", "idle during reset",
          {bip_one_n, bip_zero_n, send_data}, 3'b110);
    mrst = 1'b0;
    repeat (30) @(negedge clk);
    check(bip_one_n && bip_zero_n && !send_data, "R1", "idle after reset",
          {bip_one_n, bip_zero_n, send_data}, 3'b110);

    // R11: shift clock period
    while (shift_clk) @(negedge clk);
    while (!shift_clk) @(negedge clk);
    t0 = 0;
    while (shift_clk) begin @(negedge clk); t0++; end
    check(t0 == DIV, "R11", "shift_clk high cycles", t0, DIV);
    t0 = 0;
    while (!shift_clk) begin @(negedge clk); t0++; end
    check(t0 == DIV, "R11", "shift_clk low cycles", t0, DIV);

    // single words, both sync types, parity boundaries
    send_word(1'b1, 16'h8001, 1'b1, 1'b0, 1'b1);
    wait_quiet();
    send_word(1'b0, 16'h3C5A, 1'b1, 1'b0, 1'b1);
    wait_quiet();
    send_word(1'b0, 16'h0001, 1'b1, 1'b0, 1'b1);
    wait_quiet();

    // R7: back-to-back burst
    send_word(1'b1, 16'hFFFF, 1'b0, 1'b0, 1'b1);
    send_word(1'b0, 16'h0000, 1'b0, 1'b1, 1'b1);
    send_word(1'b1, 16'h0003, 1'b1, 1'b1, 1'b1);
    wait_quiet();

    // R8: line stays idle after enable dropped
    a0 = act_cycles;
    repeat (3*FRAME_CYC) @(negedge clk);
    check(act_cycles == a0, "R8", "no activity after stop", act_cycles - a0, 0);

    // R9: inhibit over two back-to-back words
    oinh_n = 1'b0;
    a0 = act_cycles;
    send_word(1'b1, 16'h1234, 1'b0, 1'b0, 1'b0);
    send_word(1'b0, 16'h4321, 1'b1, 1'b1, 1'b0);
    repeat (FRAME_CYC + 2*DIV) @(negedge clk);
    check(act_cycles == a0, "R9", "line held idle under inhibit", act_cycles - a0, 0);
    oinh_n = 1'b1;
    repeat (2*DIV) @(negedge clk);
    send_word(1'b0, 16'h0F0F, 1'b1, 1'b0, 1'b1);
    wait_quiet();

    // R10: abort mid-frame
    mon_en = 1'b0;
    abort_win = 1'b1;
    send_word(1'b1, 16'h5555, 1'b1, 1'b0, 1'b0);
    repeat (40) @(negedge clk);
    mrst = 1'b1;
    @(negedge clk);
    mrst = 1'b0;
    @(negedge clk);
    check(bip_one_n && bip_zero_n && !send_data, "R10", "idle after abort",
          {bip_one_n, bip_zero_n, send_data}, 3'b110);
    a0 = act_cycles;
    repeat (FRAME_CYC) @(negedge clk);
    check(act_cycles == a0, "R10", "no activity after abort", act_cycles - a0, 0);
    abort_win = 1'b0;
    mon_en = 1'b1;
    send_word(1'b1, 16'h7E81, 1'b1, 1'b0, 1'b1);
    wait_quiet();

    finish_run();
  end
endmodule